// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator

This block generates one or two pulse-width modulated waveforms from a common clock. Each channel owns three word registers on a simple write/read bus: a control word with a 6-bit clock divider and a stop-mode bit, a duty word with a 10-bit high count and a force-high flag, and a period word with a 10-bit terminal count. A divider turns the input clock into a tick every (divider+1) cycles. A period counter steps on those ticks from zero up to the terminal count, and the output is high while the counter is below the high count.

Each channel has a plain enable input that acts as its clock gate. While the enable is low, bus writes to that channel are discarded. Removing the enable either lets the current period run out before the output parks low, or parks it low at once, as the stop-mode bit selects. New duty and period settings move into the running copy only on a period boundary, so a waveform never contains a torn pulse.

The register bus is a control path, so it has no valid/ready handshake. A write is a one-cycle strobe, and a write always completes in the cycle it is presented, unless its channel enable is low. Read data is combinational from the address. The outputs are plain level signals with no back-pressure.

Top module: `pwm_prescaled_top`

## Requirements
- R1: Registers sit at byte offsets 0x00 (control, bits [6:0]), 0x04 (duty, bits [10:0]) and 0x08 (period, bits [9:0]). Address bits [1:0] are ignored. Reads return the written value with all other bits zero, and offset 0x0C reads zero.
- R2: The second channel uses the same three registers at offsets 0x10, 0x14 and 0x18, and it runs independently of the first.
- R3: A write to a channel whose enable input is low leaves that channel's registers unchanged.
- R4: With divider P (control [5:0]) and period value V (period [9:0]), the output period is (P+1)*(V+1) clock cycles.
- R5: With high count D (duty [9:0]), the output is high for the first (P+1)*D cycles of each period. D=0 gives a constant low output.
- R6: When duty bit 10 is set, the output is high for the whole period and D is ignored.
- R7: A high count D of V+1 or more gives a constant high output.
- R8: Duty, period and divider values written while the channel runs take effect at the next period boundary. Output starts with the stored values on the first clock edge at which the enable is seen high.
- R9: If the enable drops while control bit 6 is 0, the current period completes and the output then stays low.
- R10: If the enable drops while control bit 6 is 1, the output is low from the next clock edge.
- R11: Reset clears all registers to zero and holds every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| ch_en | input | NCH | Per-channel enable (clock gate) |
| pwm_out | output | NCH | Per-channel waveform |

## Verification
Two things can land in the same cycle: a register write, and the period boundary at which the running copy reloads. The channel's enable can also fall on that boundary. The bench writes new duty and period values in the middle of periods and across period ends, and it drops the enable in both stop modes. A behavioural model tracks the position in each period in clock cycles and judges every clock: the old values must hold up to the boundary, and the new ones must apply from it.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PRESC_W = 6;
  localparam int CNT_W   = 10;
  localparam int CTRL_W  = PRESC_W + 1;
  localparam int DUTY_W  = CNT_W + 1;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_PERIOD = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic               stop_now;
    logic [PRESC_W-1:0] presc;
    logic               full;
    logic [CNT_W-1:0]   high_cnt;
    logic [CNT_W-1:0]   term_cnt;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  reg_sel_e          sel,
  input  logic [DUTY_W-1:0] wdata,
  input  logic              clk_en,
  output pwm_cfg_t          cfg,
  output logic [DATA_W-1:0] rdata
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DUTY_W-1:0] duty_q;
  logic [CNT_W-1:0]  per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      duty_q <= '0;
      per_q  <= '0;
    end else if (wr_stb && clk_en) begin
      case (sel)
        SEL_CTRL:   ctrl_q <= wdata[CTRL_W-1:0];
        SEL_DUTY:   duty_q <= wdata;
        SEL_PERIOD: per_q  <= wdata[CNT_W-1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    cfg.stop_now = ctrl_q[PRESC_W];
    cfg.presc    = ctrl_q[PRESC_W-1:0];
    cfg.full     = duty_q[CNT_W];
    cfg.high_cnt = duty_q[CNT_W-1:0];
    cfg.term_cnt = per_q;
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_CTRL:   rdata = DATA_W'(ctrl_q);
      SEL_DUTY:   rdata = DATA_W'(duty_q);
      SEL_PERIOD: rdata = DATA_W'(per_q);
      default:    rdata = '0;
    endcase
  end

  AST_GATED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !clk_en) |=> ($stable(ctrl_q) && $stable(duty_q) && $stable(per_q))); // R3
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  AST_PRESC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear) |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/pwm_channel_core.sv
module pwm_channel_core
  import pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  pwm_cfg_t cfg,
  output logic     wave
);
  logic               run_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [PRESC_W-1:0] act_presc;
  logic [CNT_W-1:0]   act_high;
  logic [CNT_W-1:0]   act_term;
  logic               act_full;
  logic               tick;
  logic               period_end;
  logic               fast_stop;

  pwm_prescaler #(.W(PRESC_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!run_q),
    .limit (act_presc),
    .tick  (tick)
  );

  assign period_end = run_q && tick && (cnt_q == act_term);
  assign fast_stop  = run_q && !en && cfg.stop_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      cnt_q     <= '0;
      act_presc <= '0;
      act_high  <= '0;
      act_term  <= '0;
      act_full  <= 1'b0;
    end else if (!run_q) begin
      if (en) begin
        run_q     <= 1'b1;
        cnt_q     <= '0;
        act_presc <= cfg.presc;
        act_high  <= cfg.high_cnt;
        act_term  <= cfg.term_cnt;
        act_full  <= cfg.full;
      end
    end else if (fast_stop) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == act_term) begin
        cnt_q <= '0;
        if (!en) begin
          run_q <= 1'b0;
        end else begin
          act_presc <= cfg.presc;
          act_high  <= cfg.high_cnt;
          act_term  <= cfg.term_cnt;
          act_full  <= cfg.full;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign wave = run_q && (act_full || (cnt_q < act_high));

  AST_RELOAD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !period_end) |=> ($stable(act_high) && $stable(act_term) &&
                                $stable(act_full) && $stable(act_presc))); // R8
  AST_STOP_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    fast_stop |=> !wave); // R10
  AST_STOP_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !en && !cfg.stop_now && !period_end) |=> run_q); // R9
endmodule

// File: rtl/pwm_prescaled_top.sv
module pwm_prescaled_top
  import pwm_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    ch_en,
  output logic [NCH-1:0]    pwm_out
);
  localparam int CH_LSB = 4;
  localparam int CH_W   = ADDR_W - CH_LSB;

  logic [CH_W-1:0]   ch_field;
  reg_sel_e          sel;
  logic [DATA_W-1:0] ch_rdata [NCH];
  logic              addr_unused;

  assign ch_field    = bus_addr[ADDR_W-1:CH_LSB];
  assign sel         = reg_sel_e'(bus_addr[CH_LSB-1:2]);
  assign addr_unused = ^{bus_addr[1:0], bus_wdata[DATA_W-1:DUTY_W]};

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    pwm_cfg_t cfg;
    logic     hit;

    assign hit = (ch_field == CH_W'(k));

    pwm_regbank #(.DATA_W(DATA_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (bus_wr && hit),
      .sel    (sel),
      .wdata  (bus_wdata[DUTY_W-1:0]),
      .clk_en (ch_en[k]),
      .cfg    (cfg),
      .rdata  (ch_rdata[k])
    );

    pwm_channel_core u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ch_en[k]),
      .cfg   (cfg),
      .wave  (pwm_out[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NCH; k++) begin
      if (ch_field == CH_W'(k)) bus_rdata = ch_rdata[k];
    end
  end

  always_comb begin
    if (!rst_n) AST_RESET_LOW: assert (pwm_out == '0); // R11
  end
endmodule

// File: tb/tb_pwm_prescaled_top.sv
module tb_pwm_prescaled_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  ch_en = '0;
  logic [1:0]  pwm_out;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 1'b0;
  int    wd_cnt = 0;
  string cur_req = "R11";

  pwm_prescaled_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_en(ch_en), .pwm_out(pwm_out)
  );

  always #5 clk = ~clk;

  // behavioural reference: position inside the period in clock cycles
  logic [31:0] m_ctrl [2] = '{0, 0};
  logic [31:0] m_duty [2] = '{0, 0};
  logic [31:0] m_per  [2] = '{0, 0};
  bit          m_run  [2] = '{0, 0};
  bit          m_full [2] = '{0, 0};
  int          m_pos  [2] = '{0, 0};
  int          m_len  [2] = '{1, 1};
  int          m_hi   [2] = '{0, 0};

  function automatic void m_load(int c);
    int p, v, d;
    p = int'(m_ctrl[c][5:0]);
    v = int'(m_per[c][9:0]);
    d = int'(m_duty[c][9:0]);
    m_len[c]  = (p + 1) * (v + 1);
    m_hi[c]   = (p + 1) * d;
    m_full[c] = m_duty[c][10];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_ctrl[c] = 0; m_duty[c] = 0; m_per[c] = 0;
        m_run[c] = 0; m_pos[c] = 0; m_full[c] = 0; m_len[c] = 1; m_hi[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (!m_run[c]) begin
          if (ch_en[c]) begin m_run[c] = 1; m_pos[c] = 0; m_load(c); end
        end else if (!ch_en[c] && m_ctrl[c][6]) begin
          m_run[c] = 0;
        end else begin
          m_pos[c] = m_pos[c] + 1;
          if (m_pos[c] == m_len[c]) begin
            m_pos[c] = 0;
            if (!ch_en[c]) m_run[c] = 0;
            else m_load(c);
          end
        end
      end
      if (bus_wr && ch_en[bus_addr[4]]) begin
        case (bus_addr[3:2])
          2'd0: m_ctrl[bus_addr[4]] = bus_wdata & 32'h7F;
          2'd1: m_duty[bus_addr[4]] = bus_wdata & 32'h7FF;
          2'd2: m_per[bus_addr[4]]  = bus_wdata & 32'h3FF;
          default: ;
        endcase
      end
    end
  end

  function automatic bit m_expect(int c);
    return m_run[c] && (m_full[c] || (m_pos[c] < m_hi[c]));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      for (int c = 0; c < 2; c++)
        check($sformatf("%s ch%0d wave", cur_req, c), 32'(pwm_out[c]), 32'(m_expect(c)));
    end
  end

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_check(string tag, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 100000 && !done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
    end
  end

  initial begin
    // R11 reset state
    cur_req = "R11";
    wait_cyc(3);
    check("R11 outputs low in reset", 32'(pwm_out), 32'h0);
    rst_n = 1'b1;
    bus_check("R11 ctrl0 cleared", 5'h00, 32'h0);
    bus_check("R11 duty0 cleared", 5'h04, 32'h0);
    bus_check("R11 period0 cleared", 5'h08, 32'h0);
    bus_check("R11 ctrl1 cleared", 5'h10, 32'h0);

    // R3 gated writes dropped
    cur_req = "R3";
    bus_write(5'h00, 32'h05);
    bus_write(5'h14, 32'h07);
    bus_check("R3 ctrl0 unchanged while gated", 5'h00, 32'h0);
    bus_check("R3 duty1 unchanged while gated", 5'h14, 32'h0);

    // R1 masks and map
    cur_req = "R1";
    @(negedge clk); ch_en[0] = 1'b1;
    bus_write(5'h00, 32'hFFFF_FF82);
    bus_write(5'h04, 32'hFFFF_F803);
    bus_write(5'h0B, 32'hFFFF_FC05);
    bus_check("R1 ctrl masked", 5'h00, 32'h02);
    bus_check("R1 duty masked", 5'h04, 32'h003);
    bus_check("R1 period masked", 5'h08, 32'h005);
    bus_check("R1 hole reads zero", 5'h0C, 32'h0);

    // R4/R5 run with P=2 V=5 D=3
    cur_req = "R4/R5";
    wait_cyc(60);

    // R8 change mid period
    cur_req = "R8";
    wait_cyc(4);
    bus_write(5'h04, 32'h1);
    bus_write(5'h08, 32'h2);
    bus_write(5'h00, 32'h1);
    wait_cyc(40);

    // R5 zero duty
    cur_req = "R5";
    bus_write(5'h04, 32'h0);
    wait_cyc(30);
    check("R5 zero duty low", 32'(pwm_out[0]), 32'h0);

    // R6 full flag
    cur_req = "R6";
    bus_write(5'h04, 32'h402);
    wait_cyc(30);
    check("R6 full flag high", 32'(pwm_out[0]), 32'h1);
    wait_cyc(3);
    check("R6 full flag still high", 32'(pwm_out[0]), 32'h1);

    // R7 saturation
    cur_req = "R7";
    bus_write(5'h04, 32'h9);
    wait_cyc(30);
    check("R7 saturated high", 32'(pwm_out[0]), 32'h1);
    bus_write(5'h04, 32'h2);
    wait_cyc(3);

    // R9 late stop: P=1 V=2 D=2
    cur_req = "R9";
    wait_cyc(2);
    ch_en[0] = 1'b0;
    wait_cyc(12);
    check("R9 low after period end", 32'(pwm_out[0]), 32'h0);

    // R10 fast stop
    cur_req = "R10";
    ch_en[0] = 1'b1;
    bus_write(5'h00, 32'h43);
    bus_write(5'h04, 32'h400);
    wait_cyc(30);
    check("R10 high before stop", 32'(pwm_out[0]), 32'h1);
    ch_en[0] = 1'b0;
    wait_cyc(1);
    check("R10 low next clock", 32'(pwm_out[0]), 32'h0);

    // R2 second channel
    cur_req = "R2";
    ch_en = 2'b11;
    bus_write(5'h10, 32'h1);
    bus_write(5'h14, 32'h2);
    bus_write(5'h18, 32'h3);
    bus_write(5'h04, 32'h1);
    bus_write(5'h08, 32'h4);
    bus_check("R2 duty1 readback", 5'h14, 32'h2);
    bus_check("R2 period1 readback", 5'h18, 32'h3);
    bus_check("R2 duty0 independent", 5'h04, 32'h1);
    wait_cyc(80);

    finish_run();
  end
endmodule